// File: doc/BRIEF.md
# Three-Ones Serial Run Detector

This block watches a one-bit serial stream that is sampled once per rising clock edge and flags the moment a third consecutive 1 arrives. A two-bit state register remembers how many 1s have been seen in a row: none, one or two. A combinational function of that state and the live input produces both the next state and the flag, so the flag is a Mealy output. It is valid in the same cycle as the third 1, and a downstream register can capture it at the edge that consumes that bit.

The counting does not overlap. Once the flag has fired, the count starts again from zero. A fourth 1 in an unbroken run therefore does not fire, while a sixth one does. Any 0 on the input clears the count. A synchronous active-high reset clears it as well and takes priority over the input.

Top module: `triple_one_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state is cleared regardless of `din`. After `rst` falls, three fresh 1s are needed before `hit` rises, and `hit` is 0 in every cycle in which `rst` is high.
- R2: `hit` is 1 in a cycle exactly when `din` is 1 and the two previously sampled inputs since the last restart were both 1. The restart points are reset, any 0 and any previous hit.
- R3: A 0 on `din` sampled at a rising edge clears the run count, so the next 1 counts as the first.
- R4: Detection is non-overlapping. In an unbroken run of 1s, `hit` fires on the 3rd, 6th and 9th 1 and so on, and not on the 4th or 5th.
- R5: `hit` is a same-cycle function of `din`. It is never 1 while `din` is 0.
- R6: `hit` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit, sampled each rising edge |
| hit | output | 1 | High in the cycle holding the third consecutive 1 |

## Verification
The block has no parameters, so the bench builds the single default configuration. It exercises every reachable state and transition, including a reset that lands while the count stands at two. Directed runs of four and six 1s separate overlapping from non-overlapping counting. Several thousand random bits, biased toward 1s, produce long runs and frequent breaks, and a counter model in the bench gives the expected flag for each one.

// File: rtl/triple_one_detector.sv
module triple_one_detector (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  localparam logic [1:0] S_NONE = 2'b00;
  localparam logic [1:0] S_ONE  = 2'b01;
  localparam logic [1:0] S_TWO  = 2'b10;

  logic [1:0] state;
  logic [1:0] state_nx;
  logic       hit_c;

  always_comb begin
    state_nx = S_NONE;
    hit_c    = 1'b0;
    case (state)
      S_NONE: state_nx = din ? S_ONE : S_NONE;
      S_ONE:  state_nx = din ? S_TWO : S_NONE;
      S_TWO: begin
        state_nx = S_NONE;
        hit_c    = din;
      end
      default: begin
        state_nx = S_NONE;
        hit_c    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_NONE;
    else     state <= state_nx;
  end

  assign hit = hit_c & ~rst;

endmodule

module triple_one_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       hit,
  input logic [1:0] state
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> state == 2'b00);

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk) rst |-> !hit);

  // R3
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst) !din |=> state == 2'b00);

  // R4
  restart_after_hit_chk: assert property (@(posedge clk) disable iff (rst) hit |=> state == 2'b00);

  // R5
  hit_needs_one_chk: assert property (@(posedge clk) disable iff (rst) hit |-> din);

  // R6
  no_double_hit_chk: assert property (@(posedge clk) disable iff (rst) hit |=> !hit);

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (rst) state != 2'b11);

endmodule

bind triple_one_detector triple_one_detector_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .state(state)
);

// File: tb/triple_one_detector_test.sv
`timescale 1ns/1ps
module triple_one_detector_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int total = 0;
  int bad   = 0;
  int run   = 0;
  logic prev_hit = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  triple_one_detector uut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  function automatic logic expect_hit(logic r, logic d, int cnt);
    return !r && d && (cnt == 2);
  endfunction

  function automatic int next_cnt(logic r, logic d, int cnt);
    if (r || !d) return 0;
    return (cnt == 2) ? 0 : cnt + 1;
  endfunction

  task automatic step(input logic r, input logic d, input string tag);
    logic exp;
    @(negedge clk);
    rst = r;
    din = d;
    #1.5;
    exp = expect_hit(r, d, run);
    total++;
    if (hit !== exp) begin
      bad++;
      $display("FAIL %s: hit=%b expected=%b (din=%b rst=%b run=%0d)", tag, hit, exp, d, r, run);
    end
    total++;
    if (prev_hit && hit) begin
      bad++;
      $display("FAIL R6: hit=1 expected=0 in cycle after a hit");
    end
    prev_hit = hit;
    @(posedge clk);
    run = next_cnt(r, d, run);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(1, 1, "R1");
    step(1, 1, "R1");
    step(0, 1, "R1");
    step(0, 1, "R1");
    step(0, 1, "R2");
    step(0, 0, "R3");
    step(0, 1, "R3");
    step(0, 1, "R3");
    step(0, 0, "R3");
    step(0, 1, "R3");
    step(0, 1, "R3");
    step(0, 1, "R2");
    step(0, 0, "R5");
    for (int i = 0; i < 4; i++) step(0, 1, "R4");
    step(0, 0, "R4");
    for (int i = 0; i < 6; i++) step(0, 1, "R4");
    step(0, 0, "R5");
    step(0, 1, "R1");
    step(0, 1, "R1");
    step(1, 1, "R1");
    step(0, 1, "R1");
    step(0, 1, "R1");
    step(0, 1, "R1");
    for (int i = 0; i < 4000; i++) begin
      logic b;
      logic r;
      b = ($urandom % 5) != 0;
      r = ($urandom % 97) == 0;
      step(r, b, "R2 R4 R5");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule